// File: doc/BRIEF.md
# Buffered UART Transmitter with Half-Duplex Turnaround

The block serialises bytes written by a host into asynchronous frames on a single line. Bytes first go into a 256-entry FIFO. A shift register takes them from the FIFO and sends one start bit (0), eight data bits starting with the least significant bit, and one stop bit (1). The line idles high. Bit timing comes from an external oversampling tick. Each bit lasts 16, 8 or 4 ticks, as selected. When the FIFO holds another byte at the end of a stop bit, that byte's start bit follows at once, with no idle time on the line.

Two status outputs show whether the FIFO is empty and whether the whole path is empty. The whole path is empty when the FIFO is empty and the shifter has finished its last stop bit. A level interrupt tells the host that it can refill the FIFO. In normal mode it is raised when the FIFO fill drops below a programmable trigger level, or when the FIFO is empty. In half-duplex mode the interrupt follows path-empty instead.

Half-duplex mode also drives an active-low direction output while data is pending or being sent. This output goes to one of two pins, selected by an input. After the last stop bit the output stays asserted for a programmed number of bit times (0 to 15), so that a line transceiver can be turned around safely.

Top module: `txu_top`

## Requirements
- R1: After synchronous reset `txd_o`, `rts_n_o` and `dtr_n_o` are 1, `hold_empty_o` and `shift_empty_o` are 1, and `fifo_level_o` is 0.
- R2: Each byte is sent as a 0 start bit, then 8 data bits with the LSB first, then a 1 stop bit. Each bit lasts N oversampling ticks, where `osr_sel_i` = 0 gives N=16, 1 gives N=8, 2 gives N=4 and 3 gives N=16.
- R3: The FIFO accepts at most 256 bytes. A write while `fifo_level_o` is 256 is ignored. Bytes leave in the order they were written.
- R4: `hold_empty_o` is 1 exactly when `fifo_level_o` is 0.
- R5: `shift_empty_o` is 1 only when the FIFO is empty and the last stop bit has been fully sent. It is 0 while a frame is on the line, even if the FIFO is already empty.
- R6: When `hd_en_i` is 0, `irq_src_o` = (`fifo_level_o` == 0) or (`fifo_level_o` < `trig_lvl_i`), and `irq_o` = `irq_src_o` AND `irq_en_i`.
- R7: When `hd_en_i` is 1, `irq_src_o` equals `shift_empty_o`, and `irq_o` = `irq_src_o` AND `irq_en_i`.
- R8: When `hd_en_i` is 1, the direction output is driven low while the FIFO holds data or a frame is being sent. `dir_sel_i` = 0 uses `rts_n_o` and 1 uses `dtr_n_o`, and the other pin stays 1. When `hd_en_i` is 0, both pins are 1.
- R9: In half-duplex mode the direction output returns to 1 exactly `turn_dly_i` bit times after the end of the final stop bit. A value of 0 releases it at the end of the stop bit. The release therefore comes (10 + `turn_dly_i`) bit times after the last start bit begins.
- R10: If a byte is written while the release delay is running, the direction output stays low. The delay then starts again from the end of that byte's stop bit.
- R11: While the FIFO is not empty, each frame begins exactly 10 bit times after the previous one began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick_i | input | 1 | Oversampling tick, one clock wide |
| wr_en_i | input | 1 | Write strobe for the transmit FIFO |
| wr_data_i | input | 8 | Byte to transmit |
| osr_sel_i | input | 2 | Ticks per bit: 0=16, 1=8, 2=4, 3=16 |
| trig_lvl_i | input | 9 | FIFO fill threshold for the refill interrupt |
| irq_en_i | input | 1 | Interrupt enable |
| hd_en_i | input | 1 | Half-duplex direction control enable |
| turn_dly_i | input | 4 | Release delay in bit times |
| dir_sel_i | input | 1 | Direction pin select: 0 RTS, 1 DTR |
| txd_o | output | 1 | Serial line |
| rts_n_o | output | 1 | Active-low direction output, choice 0 |
| dtr_n_o | output | 1 | Active-low direction output, choice 1 |
| fifo_level_o | output | 9 | Bytes held in the FIFO |
| hold_empty_o | output | 1 | FIFO empty |
| shift_empty_o | output | 1 | FIFO and shifter both empty |
| irq_src_o | output | 1 | Unmasked refill interrupt source |
| irq_o | output | 1 | Masked refill interrupt |

## Verification
The direction-control assertions assume that `hd_en_i` and `dir_sel_i` change only while the path is empty. They also assume that `osr_sel_i` changes only between frames, so that each bit time stays constant within a frame. The bench changes these settings only after `shift_empty_o` has been seen high. It then waits a further bit time before the next write. The oversampling tick pulses every second clock whenever it is enabled. Writes come in single strobes or in back-to-back bursts, and each burst is kept far below the FIFO depth, except in the fill test. In the fill test the tick is stopped, so that no byte leaves the FIFO while it fills.

// File: rtl/txu_pkg.sv
package txu_pkg;

    localparam int DATA_W    = 8;
    localparam int FRAME_LEN = DATA_W + 2;
    localparam int DLY_W     = 4;

    typedef enum logic [1:0] {
        OSR_X16 = 2'd0,
        OSR_X8  = 2'd1,
        OSR_X4  = 2'd2,
        OSR_RSV = 2'd3
    } osr_e;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_SEND = 1'b1
    } sh_state_e;

    typedef enum logic [1:0] {
        DR_OFF  = 2'd0,
        DR_ON   = 2'd1,
        DR_HOLD = 2'd2
    } dir_state_e;

    // Bits still to leave the shifter (stop bit included) and bits left to send.
    typedef struct packed {
        logic [DATA_W:0] bits;
        logic [3:0]      left;
    } frame_t;

    function automatic logic [4:0] osr_ratio(osr_e sel);
        case (sel)
            OSR_X8:  return 5'd8;
            OSR_X4:  return 5'd4;
            default: return 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/txu_bitclk.sv
module txu_bitclk
    import txu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  osr_e osr,
    output logic bit_tick
);

    logic [4:0] cnt;
    logic       last;

    assign last     = (cnt + 5'd1) >= osr_ratio(osr);
    assign bit_tick = tick && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            if (last) cnt <= '0;
            else      cnt <= cnt + 5'd1;
        end
    end

endmodule

// File: rtl/txu_fifo.sv
module txu_fifo #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [WIDTH-1:0]         wr_data,
    input  logic                     rd_en,
    output logic [WIDTH-1:0]         rd_data,
    output logic [$clog2(DEPTH):0]   level,
    output logic                     empty,
    output logic                     full
);

    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [LW-1:0]    count;
    logic             do_wr, do_rd;

    assign empty   = (count == '0);
    assign full    = (count == LW'(DEPTH));
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rp];
    assign level   = count;

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R3: a full FIFO that is not drained stays full, so no entry is overwritten
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en) |=> full);

    // R3: fill never exceeds the depth
    a_r3_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(DEPTH));

endmodule

// File: rtl/txu_shift.sv
module txu_shift
    import txu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              pop,
    output logic              txd,
    output logic              busy,
    output logic              frame_end
);

    sh_state_e st;
    frame_t    fr;
    logic      txd_q;
    logic      stop_done;
    logic      load;

    assign stop_done = (st == SH_SEND) && (fr.left == 4'd0);
    assign load      = bit_tick && !fifo_empty && ((st == SH_IDLE) || stop_done);
    assign frame_end = bit_tick && stop_done && fifo_empty;
    assign pop       = load;
    assign txd       = txd_q;
    assign busy      = (st == SH_SEND);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SH_IDLE;
            txd_q   <= 1'b1;
            fr.bits <= '1;
            fr.left <= '0;
        end else if (load) begin
            st      <= SH_SEND;
            txd_q   <= 1'b0;
            fr.bits <= {1'b1, fifo_data};
            fr.left <= 4'(FRAME_LEN - 1);
        end else if (frame_end) begin
            st      <= SH_IDLE;
            txd_q   <= 1'b1;
        end else if (bit_tick && st == SH_SEND) begin
            txd_q   <= fr.bits[0];
            fr.bits <= {1'b1, fr.bits[DATA_W:1]};
            fr.left <= fr.left - 4'd1;
        end
    end

    // R2: an idle shifter holds the line high
    a_r2_idle_high: assert property (@(posedge clk) disable iff (rst)
        (st == SH_IDLE) |-> txd_q);

    // R11: a pending byte starts right at the end of the previous stop bit
    a_r11_reload: assert property (@(posedge clk) disable iff (rst)
        (stop_done && bit_tick && !fifo_empty) |=> (!txd_q && st == SH_SEND));

endmodule

// File: rtl/txu_dir.sv
module txu_dir
    import txu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_tick,
    input  logic             en,
    input  logic [DLY_W-1:0] dly,
    input  logic             pending,
    input  logic             busy,
    input  logic             frame_end,
    output logic             dir_on
);

    dir_state_e       st;
    logic [DLY_W-1:0] cnt;

    assign dir_on = (st != DR_OFF);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st  <= DR_OFF;
            cnt <= '0;
        end else begin
            case (st)
                DR_OFF: begin
                    if (pending || busy) st <= DR_ON;
                end
                DR_ON: begin
                    if (frame_end) begin
                        if (dly == '0) begin
                            st <= DR_OFF;
                        end else begin
                            st  <= DR_HOLD;
                            cnt <= dly;
                        end
                    end
                end
                DR_HOLD: begin
                    if (pending) begin
                        st <= DR_ON;
                    end else if (bit_tick) begin
                        if (cnt == DLY_W'(1)) st <= DR_OFF;
                        cnt <= cnt - 1'b1;
                    end
                end
                default: st <= DR_OFF;
            endcase
        end
    end

    // R8: while enabled, a frame on the line always has the driver on
    a_r8_on_while_busy: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && busy) |-> (st != DR_OFF));

    // R9: the turnaround hold only runs with the shifter idle
    a_r9_hold_quiet: assert property (@(posedge clk) disable iff (rst)
        (st == DR_HOLD) |-> !busy);

endmodule

// File: rtl/txu_top.sv
module txu_top
    import txu_pkg::*;
#(
    parameter int FIFO_DEPTH = 256
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        os_tick_i,
    input  logic                        wr_en_i,
    input  logic [7:0]                  wr_data_i,
    input  logic [1:0]                  osr_sel_i,
    input  logic [$clog2(FIFO_DEPTH):0] trig_lvl_i,
    input  logic                        irq_en_i,
    input  logic                        hd_en_i,
    input  logic [3:0]                  turn_dly_i,
    input  logic                        dir_sel_i,
    output logic                        txd_o,
    output logic                        rts_n_o,
    output logic                        dtr_n_o,
    output logic [$clog2(FIFO_DEPTH):0] fifo_level_o,
    output logic                        hold_empty_o,
    output logic                        shift_empty_o,
    output logic                        irq_src_o,
    output logic                        irq_o
);

    localparam int LW = $clog2(FIFO_DEPTH) + 1;

    logic              bit_tick;
    logic              pop, busy, frame_end, dir_on;
    logic              f_empty, f_full;
    logic [DATA_W-1:0] f_data;
    logic [LW-1:0]     f_level;

    txu_bitclk u_bitclk (
        .clk      (clk),
        .rst      (rst),
        .tick     (os_tick_i),
        .osr      (osr_e'(osr_sel_i)),
        .bit_tick (bit_tick)
    );

    txu_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en_i),
        .wr_data (wr_data_i),
        .rd_en   (pop),
        .rd_data (f_data),
        .level   (f_level),
        .empty   (f_empty),
        .full    (f_full)
    );

    txu_shift u_shift (
        .clk        (clk),
        .rst        (rst),
        .bit_tick   (bit_tick),
        .fifo_empty (f_empty),
        .fifo_data  (f_data),
        .pop        (pop),
        .txd        (txd_o),
        .busy       (busy),
        .frame_end  (frame_end)
    );

    txu_dir u_dir (
        .clk       (clk),
        .rst       (rst),
        .bit_tick  (bit_tick),
        .en        (hd_en_i),
        .dly       (turn_dly_i),
        .pending   (!f_empty),
        .busy      (busy),
        .frame_end (frame_end),
        .dir_on    (dir_on)
    );

    assign fifo_level_o  = f_level;
    assign hold_empty_o  = f_empty;
    assign shift_empty_o = f_empty && !busy;

    assign irq_src_o = hd_en_i ? shift_empty_o : (f_empty || (f_level < trig_lvl_i));
    assign irq_o     = irq_src_o && irq_en_i;

    assign rts_n_o = !(dir_on && !dir_sel_i);
    assign dtr_n_o = !(dir_on && dir_sel_i);

    // R9: the driver is released only with the line back at idle high
    a_r9_release_line_idle: assert property (@(posedge clk) disable iff (rst)
        (($rose(rts_n_o) || $rose(dtr_n_o)) && hd_en_i && $past(hd_en_i) && $stable(dir_sel_i))
        |-> txd_o);

    // R8: never both direction pins active at once
    a_r8_one_pin: assert property (@(posedge clk) disable iff (rst)
        (rts_n_o || dtr_n_o));

    // R3: the FIFO never reports a fill above its depth; f_full unused otherwise
    a_r3_full_level: assert property (@(posedge clk) disable iff (rst)
        f_full |-> (fifo_level_o == LW'(FIFO_DEPTH)));

endmodule

// File: tb/txu_top_tb.sv
module txu_top_tb_top;

    localparam int DEPTH = 256;
    localparam int LW    = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          os_tick = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = '0;
    logic [1:0]    osr_sel = 2'd2;
    logic [LW-1:0] trig_lvl = '0;
    logic          irq_en = 1'b0;
    logic          hd_en = 1'b0;
    logic [3:0]    turn_dly = '0;
    logic          dir_sel = 1'b0;
    logic          txd_o, rts_n_o, dtr_n_o, hold_empty_o, shift_empty_o, irq_src_o, irq_o;
    logic [LW-1:0] fifo_level_o;

    always #5 clk = ~clk;

    txu_top #(.FIFO_DEPTH(DEPTH)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .os_tick_i     (os_tick),
        .wr_en_i       (wr_en),
        .wr_data_i     (wr_data),
        .osr_sel_i     (osr_sel),
        .trig_lvl_i    (trig_lvl),
        .irq_en_i      (irq_en),
        .hd_en_i       (hd_en),
        .turn_dly_i    (turn_dly),
        .dir_sel_i     (dir_sel),
        .txd_o         (txd_o),
        .rts_n_o       (rts_n_o),
        .dtr_n_o       (dtr_n_o),
        .fifo_level_o  (fifo_level_o),
        .hold_empty_o  (hold_empty_o),
        .shift_empty_o (shift_empty_o),
        .irq_src_o     (irq_src_o),
        .irq_o         (irq_o)
    );

    int  n_chk = 0;
    int  n_bad = 0;
    int  cyc = 0;
    int  cur_p = 8;
    int  rx_cnt = 0;
    int  rel_cyc = 0;
    bit  rel_seen = 0;
    bit  tick_en = 0;
    bit  done = 0;
    bit  prev_both = 1;
    byte unsigned exp_q[$];
    int  st_q[$];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) os_tick <= 1'b0;
        else     os_tick <= tick_en && !os_tick;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int ratio(input int sel);
        if (sel == 1) return 8;
        if (sel == 2) return 4;
        return 16;
    endfunction

    function automatic int exp_irq(input int lvl, input int trig, input bit en,
                                   input bit hd, input bit sh_empty);
        bit src;
        src = hd ? sh_empty : ((lvl == 0) || (lvl < trig));
        return (en && src) ? 1 : 0;
    endfunction

    // Line receiver: samples mid-bit with the current bit period
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && txd_o == 1'b0) begin
                int s0;
                byte unsigned b;
                s0 = cyc;
                st_q.push_back(s0);
                repeat (cur_p / 2) @(negedge clk);
                check("R2 start bit", int'(txd_o), 0);
                b = '0;
                for (int k = 0; k < 8; k++) begin
                    repeat (cur_p) @(negedge clk);
                    b[k] = txd_o;
                end
                repeat (cur_p) @(negedge clk);
                check("R2 stop bit", int'(txd_o), 1);
                rx_cnt++;
                if (exp_q.size() == 0) begin
                    check("R3 unexpected frame", int'(b), -1);
                end else begin
                    check("R2 R3 frame data", int'(b), int'(exp_q.pop_front()));
                end
            end
        end
    end

    // Direction release monitor
    always @(negedge clk) begin
        if (!rst) begin
            if ((rts_n_o && dtr_n_o) && !prev_both) begin
                rel_seen = 1'b1;
                rel_cyc  = cyc;
            end
            prev_both = rts_n_o && dtr_n_o;
        end
    end

    task automatic set_osr(input int sel);
        osr_sel = 2'(sel);
        cur_p   = ratio(sel) * 2;
    endtask

    task automatic push_byte(input byte unsigned b, input bit accept);
        wr_data = b;
        wr_en   = 1'b1;
        if (accept) exp_q.push_back(b);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (shift_empty_o !== 1'b1 && guard < 60000) begin
            @(negedge clk);
            guard++;
        end
        repeat (cur_p) @(negedge clk);
    endtask

    task automatic wait_rel();
        int guard = 0;
        while (!rel_seen && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic hd_run(input int dly, input bit sel, input int nbytes);
        hd_en = 1'b1; dir_sel = sel; turn_dly = 4'(dly); irq_en = 1'b1;
        @(negedge clk);
        rel_seen = 0;
        st_q.delete();
        for (int i = 0; i < nbytes; i++) push_byte(byte'($urandom), 1'b1);
        repeat (cur_p * 3) @(negedge clk);
        check("R8 selected pin active", int'(sel ? dtr_n_o : rts_n_o), 0);
        check("R8 other pin idle", int'(sel ? rts_n_o : dtr_n_o), 1);
        check("R7 irq while sending", int'(irq_o), 0);
        wait_idle();
        wait_rel();
        check("R9 released", int'(rel_seen), 1);
        if (st_q.size() > 0)
            check("R9 release time", rel_cyc - st_q[st_q.size() - 1], (10 + dly) * cur_p);
        check("R7 irq when path empty", int'(irq_o), 1);
    endtask

    initial begin
        void'($urandom(32'd20417));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 txd", int'(txd_o), 1);
        check("R1 rts_n", int'(rts_n_o), 1);
        check("R1 dtr_n", int'(dtr_n_o), 1);
        check("R1 hold_empty", int'(hold_empty_o), 1);
        check("R1 shift_empty", int'(shift_empty_o), 1);
        check("R1 level", int'(fifo_level_o), 0);

        tick_en = 1;
        set_osr(2);
        repeat (cur_p) @(negedge clk);
        push_byte(8'hA5, 1'b1);
        wait_idle();
        check("R2 one frame x4", rx_cnt, 1);

        // R5 mid-frame status, R6 irq on empty FIFO
        irq_en = 1'b1; trig_lvl = '0;
        push_byte(8'h3C, 1'b1);
        repeat (cur_p * 4) @(negedge clk);
        check("R4 hold empty mid-frame", int'(hold_empty_o), 1);
        check("R5 shift not empty mid-frame", int'(shift_empty_o), 0);
        check("R6 irq on empty", int'(irq_o), exp_irq(0, 0, 1, 0, 0));
        wait_idle();
        check("R5 shift empty after stop", int'(shift_empty_o), 1);

        set_osr(1); repeat (cur_p) @(negedge clk);
        push_byte(8'h81, 1'b1); wait_idle();
        set_osr(0); repeat (cur_p) @(negedge clk);
        push_byte(8'h5E, 1'b1); wait_idle();
        set_osr(3); repeat (cur_p) @(negedge clk);
        push_byte(8'h07, 1'b1); wait_idle();
        check("R2 frames at x8 x16", rx_cnt, 5);

        // R11 back-to-back frames
        set_osr(2); repeat (cur_p) @(negedge clk);
        st_q.delete();
        push_byte(8'h11, 1'b1); push_byte(8'hEE, 1'b1); push_byte(8'h00, 1'b1);
        wait_idle();
        check("R11 frame count", st_q.size(), 3);
        for (int i = 1; i < st_q.size(); i++)
            check("R11 frame spacing", st_q[i] - st_q[i - 1], 10 * cur_p);

        // Random bursts
        for (int r = 0; r < 6; r++) begin
            int n;
            set_osr(int'($urandom % 3));
            repeat (cur_p) @(negedge clk);
            st_q.delete();
            n = 1 + int'($urandom % 12);
            for (int i = 0; i < n; i++) push_byte(byte'($urandom), 1'b1);
            wait_idle();
            for (int i = 1; i < st_q.size(); i++)
                check("R11 burst spacing", st_q[i] - st_q[i - 1], 10 * cur_p);
        end
        check("R3 all random bytes out", exp_q.size(), 0);

        // Fill with the tick stopped
        tick_en = 0;
        set_osr(0);
        repeat (4) @(negedge clk);
        trig_lvl = 9'd4; irq_en = 1'b1;
        check("R6 irq at level 0", int'(irq_o), exp_irq(0, 4, 1, 0, 1));
        begin
            int base;
            base = rx_cnt;
            for (int i = 0; i < 260; i++) begin
                int lv;
                push_byte(byte'($urandom), i < DEPTH);
                lv = (i + 1 < DEPTH) ? i + 1 : DEPTH;
                check("R3 level while filling", int'(fifo_level_o), lv);
                if (i < 6 || i > 253) begin
                    check("R4 hold empty", int'(hold_empty_o), 0);
                    check("R6 irq vs trigger", int'(irq_o), exp_irq(lv, 4, 1, 0, 0));
                end
            end
            irq_en = 1'b0;
            @(negedge clk);
            check("R6 irq masked", int'(irq_o), 0);
            check("R6 source unmasked", int'(irq_src_o), 0);
            set_osr(2);
            tick_en = 1;
            wait_idle();
            check("R3 exactly depth sent", rx_cnt - base, DEPTH);
            check("R3 extras ignored", exp_q.size(), 0);
        end

        // Half-duplex turnaround
        hd_run(0, 1'b0, 1);
        hd_run(3, 1'b1, 2);
        set_osr(1); repeat (cur_p) @(negedge clk);
        hd_run(15, 1'b0, 1);
        set_osr(2); repeat (cur_p) @(negedge clk);
        hd_run(7, 1'b1, 3);

        // R10 write during the release delay
        hd_en = 1'b1; dir_sel = 1'b0; turn_dly = 4'd5;
        @(negedge clk);
        rel_seen = 0;
        st_q.delete();
        push_byte(8'h9A, 1'b1);
        wait_idle();
        check("R10 still asserted in hold", int'(rts_n_o), 0);
        check("R10 not yet released", int'(rel_seen), 0);
        push_byte(8'h42, 1'b1);
        wait_idle();
        wait_rel();
        check("R10 frames", st_q.size(), 2);
        if (st_q.size() == 2)
            check("R10 delay restarted", rel_cyc - st_q[1], 15 * cur_p);

        // R8 disabled mode keeps both pins high
        hd_en = 1'b0;
        @(negedge clk);
        push_byte(8'hC3, 1'b1);
        repeat (cur_p * 3) @(negedge clk);
        check("R8 rts idle when disabled", int'(rts_n_o), 1);
        check("R8 dtr idle when disabled", int'(dtr_n_o), 1);
        wait_idle();
        check("R3 final queue empty", exp_q.size(), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule